// File: doc/BRIEF.md
# Multi-Rate Telemetry Limit Monitor

This block watches a power controller's stored telemetry results: output voltage and output current for each rail, input voltage, input current and temperature. Each class of quantity is checked on its own cadence, counted in ticks of a one-microsecond strobe. The monitor never waits for the converter. When a class's interval runs out, it takes whatever result value is present on its input at that moment. It compares that value against programmable fault and warning limits.

A limit crossing sets a sticky warning or fault bit for that quantity. A fault bit that was clear before also produces a one-cycle response request. A single alert line summarises every status bit that is not masked. A separate strobe marks when a current-sharing evaluation is due.

The output-current interval grows with the number of rails that software has configured. Rails beyond that count are not checked. When several intervals expire in the same cycle, the classes are handled one per cycle in a fixed order. This lets one comparator bank serve all classes.

Top module: `tlm_limit_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all warning bits, fault bits and response requests are 0, and `bal_strobe` and `alert` are 0.
- R2: Output voltages are checked once every `VOUT_TICKS` ticks. Counting starts from reset. The status change is visible after the clock edge that follows the edge sampling the expiring tick, when no higher-priority class is waiting.
- R3: Output currents are checked once every `IOUT_BASE_TICKS × rails` ticks. `rails` is `cfg_rails` clamped to the range 1..`N_RAILS`, so 0 counts as 1. Rails with an index at or above `rails` never set a flag.
- R4: Input voltage and input current are checked together once every `INPUT_TICKS` ticks. Temperature is checked once every `TEMP_TICKS` ticks.
- R5: `bal_strobe` is a one-cycle pulse that rises on the edge sampling every `BAL_TICKS`-th tick.
- R6: Each limit vector is packed as follows: bits [W-1:0] hold the over-fault limit, [2W-1:W] the over-warning limit, [3W-1:2W] the under-warning limit and [4W-1:3W] the under-fault limit. The temperature vector holds only the fault limit in [W-1:0] and the warning limit in [2W-1:W]. A value strictly above the over-fault limit, or strictly below the under-fault limit, sets the fault bit. A value strictly above the over-warning limit, or strictly below the under-warning limit, sets the warning bit. Temperature has no under limits. Values are unsigned.
- R7: Status bit index q maps as follows. Output voltage of rail r is q=r. Output current of rail r is q=`N_RAILS`+r. Input voltage is q=2·`N_RAILS`. Input current is 2·`N_RAILS`+1. Temperature is 2·`N_RAILS`+2. Bits stay set until `clr_status` is high at a clock edge. A check that flags on that same edge leaves its bit set.
- R8: `fault_req[q]` is high for exactly one cycle, in the cycle where fault bit q goes from 0 to 1.
- R9: `alert` is high exactly when some warning bit with a 0 in `warn_mask`, or some fault bit with a 0 in `fault_mask`, is set. It follows the masks without delay.
- R10: When intervals expire on the same edge, the classes are handled on successive edges in this order: output voltage, output current, input, temperature.
- R11: Interval counters advance only on edges where `tick_us` is high. A result value is only looked at on its class's service edge, so changes between checks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| cfg_rails | input | $clog2(N_RAILS+1) | Number of configured rails |
| clr_status | input | 1 | Clears all status bits |
| vout_res | input | N_RAILS·DATA_W | Latest output-voltage results, rail 0 in the low bits |
| iout_res | input | N_RAILS·DATA_W | Latest output-current results, rail 0 in the low bits |
| vin_res | input | DATA_W | Latest input-voltage result |
| iin_res | input | DATA_W | Latest input-current result |
| temp_res | input | DATA_W | Latest temperature result |
| vout_lim | input | 4·DATA_W | Output-voltage limits, packed per R6 |
| iout_lim | input | 4·DATA_W | Output-current limits, packed per R6 |
| vin_lim | input | 4·DATA_W | Input-voltage limits, packed per R6 |
| iin_lim | input | 4·DATA_W | Input-current limits, packed per R6 |
| temp_lim | input | 2·DATA_W | Temperature fault and warning limits |
| warn_mask | input | 2·N_RAILS+3 | Warning bits excluded from alert |
| fault_mask | input | 2·N_RAILS+3 | Fault bits excluded from alert |
| warn_status | output | 2·N_RAILS+3 | Sticky warning bits |
| fault_status | output | 2·N_RAILS+3 | Sticky fault bits |
| fault_req | output | 2·N_RAILS+3 | One-cycle response request per newly set fault |
| bal_strobe | output | 1 | Current-balancing evaluation strobe |
| alert | output | 1 | OR of unmasked status bits |

## Verification
A wrong interval counter or pending bit shows up as a status bit that is set one or more edges too early or too late. The bench therefore checks the status one edge before the expected service edge and again one edge after it. A fault in the arbiter changes the edge on which each class appears when all timers expire together. A fault in the comparators or the index mapping sets the wrong bit on the very first service edge. Broken sticky or request logic shows within one cycle of a clear, or of a repeated check of a quantity that is still out of range.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        CLS_VOUT  = 2'd0,
        CLS_IOUT  = 2'd1,
        CLS_INPUT = 2'd2,
        CLS_TEMP  = 2'd3
    } tlm_class_e;

    typedef struct packed {
        logic warn;
        logic fault;
    } tlm_verdict_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int qi_vout(input int rail);
        return rail;
    endfunction

    function automatic int qi_iout(input int rail, input int nrails);
        return nrails + rail;
    endfunction

    function automatic int qi_vin(input int nrails);
        return 2 * nrails;
    endfunction

    function automatic int qi_iin(input int nrails);
        return 2 * nrails + 1;
    endfunction

    function automatic int qi_temp(input int nrails);
        return 2 * nrails + 2;
    endfunction

endpackage

// File: rtl/tlm_interval_timer.sv
module tlm_interval_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    // period is never zero; >= tolerates a period that shrinks mid-count
    assign expire = tick && (cnt_q >= (period - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/tlm_arbiter.sv
module tlm_arbiter #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] expire,
    output logic [NC-1:0] grant
);
    logic [NC-1:0] pend_q;

    // lowest index wins: voltage, current, input, temperature
    always_comb begin
        grant = '0;
        for (int i = 0; i < NC; i++) begin
            if (pend_q[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~grant) | expire;
    end
endmodule

// File: rtl/tlm_check_lane.sv
module tlm_check_lane
    import tlm_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         en,
    input  logic         under_en,
    input  logic [W-1:0] value,
    input  logic [W-1:0] over_flt,
    input  logic [W-1:0] over_wrn,
    input  logic [W-1:0] under_wrn,
    input  logic [W-1:0] under_flt,
    output tlm_verdict_t verdict
);
    logic hi_f, hi_w, lo_f, lo_w;

    always_comb begin
        hi_f = value > over_flt;
        hi_w = value > over_wrn;
        lo_f = under_en && (value < under_flt);
        lo_w = under_en && (value < under_wrn);
        verdict.fault = en && (hi_f || lo_f);
        verdict.warn  = en && (hi_w || lo_w);
    end
endmodule

// File: rtl/tlm_status_bank.sv
module tlm_status_bank #(
    parameter int NQ = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [NQ-1:0] warn_det,
    input  logic [NQ-1:0] fault_det,
    output logic [NQ-1:0] warn_q,
    output logic [NQ-1:0] fault_q,
    output logic [NQ-1:0] req_q
);
    logic [NQ-1:0] warn_keep, fault_keep;

    assign warn_keep  = clr ? '0 : warn_q;
    assign fault_keep = clr ? '0 : fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warn_q  <= '0;
            fault_q <= '0;
            req_q   <= '0;
        end else begin
            warn_q  <= warn_keep | warn_det;   // detection beats clear
            fault_q <= fault_keep | fault_det;
            req_q   <= fault_det & ~fault_q;
        end
    end
endmodule

// File: rtl/tlm_limit_monitor.sv
module tlm_limit_monitor
    import tlm_pkg::*;
#(
    parameter int DATA_W          = 12,
    parameter int N_RAILS         = 2,
    parameter int VOUT_TICKS      = 200,
    parameter int IOUT_BASE_TICKS = 200,
    parameter int INPUT_TICKS     = 2000,
    parameter int BAL_TICKS       = 2000,
    parameter int TEMP_TICKS      = 100000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick_us,
    input  logic [$clog2(N_RAILS+1)-1:0]  cfg_rails,
    input  logic                          clr_status,
    input  logic [N_RAILS*DATA_W-1:0]     vout_res,
    input  logic [N_RAILS*DATA_W-1:0]     iout_res,
    input  logic [DATA_W-1:0]             vin_res,
    input  logic [DATA_W-1:0]             iin_res,
    input  logic [DATA_W-1:0]             temp_res,
    input  logic [4*DATA_W-1:0]           vout_lim,
    input  logic [4*DATA_W-1:0]           iout_lim,
    input  logic [4*DATA_W-1:0]           vin_lim,
    input  logic [4*DATA_W-1:0]           iin_lim,
    input  logic [2*DATA_W-1:0]           temp_lim,
    input  logic [2*N_RAILS+2:0]          warn_mask,
    input  logic [2*N_RAILS+2:0]          fault_mask,
    output logic [2*N_RAILS+2:0]          warn_status,
    output logic [2*N_RAILS+2:0]          fault_status,
    output logic [2*N_RAILS+2:0]          fault_req,
    output logic                          bal_strobe,
    output logic                          alert
);
    localparam int NQ     = 2 * N_RAILS + 3;
    localparam int RAIL_W = $clog2(N_RAILS + 1);
    localparam int LANES  = (N_RAILS > 2) ? N_RAILS : 2;
    localparam int MAX_P  = umax(umax(umax(VOUT_TICKS, IOUT_BASE_TICKS * N_RAILS),
                                      umax(INPUT_TICKS, BAL_TICKS)), TEMP_TICKS);
    localparam int CW     = $clog2(MAX_P + 1);

    typedef struct packed {
        logic [DATA_W-1:0] uf;
        logic [DATA_W-1:0] uw;
        logic [DATA_W-1:0] ow;
        logic [DATA_W-1:0] of;
    } lim_t;

    // ---------------- rail count and interval timers ----------------
    logic [RAIL_W-1:0]      rails_eff;
    logic [CW-1:0]          cls_period [NUM_CLASSES];
    logic [NUM_CLASSES-1:0] cls_expire;
    logic [NUM_CLASSES-1:0] arb_grant;
    logic                   bal_expire;
    logic                   bal_q;

    assign rails_eff = (cfg_rails == '0)                  ? RAIL_W'(1) :
                       (cfg_rails > RAIL_W'(N_RAILS))     ? RAIL_W'(N_RAILS) :
                                                            cfg_rails;

    assign cls_period[CLS_VOUT]  = CW'(VOUT_TICKS);
    assign cls_period[CLS_IOUT]  = CW'(IOUT_BASE_TICKS) * CW'(rails_eff);
    assign cls_period[CLS_INPUT] = CW'(INPUT_TICKS);
    assign cls_period[CLS_TEMP]  = CW'(TEMP_TICKS);

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_timer
        tlm_interval_timer #(.CW(CW)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick_us),
            .period (cls_period[c]),
            .expire (cls_expire[c])
        );
    end

    tlm_interval_timer #(.CW(CW)) u_bal_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_us),
        .period (CW'(BAL_TICKS)),
        .expire (bal_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) bal_q <= 1'b0;
        else     bal_q <= bal_expire;
    end
    assign bal_strobe = bal_q;

    tlm_arbiter #(.NC(NUM_CLASSES)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .expire (cls_expire),
        .grant  (arb_grant)
    );

    // ---------------- shared comparator lanes ----------------
    lim_t         lim_vo, lim_io, lim_vi, lim_ii;
    tlm_verdict_t lane_vd [LANES];

    assign lim_vo = vout_lim;
    assign lim_io = iout_lim;
    assign lim_vi = vin_lim;
    assign lim_ii = iin_lim;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DATA_W-1:0] v_vout, v_iout;
        logic              rail_on;
        logic [DATA_W-1:0] val;
        lim_t              lim;
        logic              en, under_en;

        if (l < N_RAILS) begin : g_rail
            assign v_vout  = vout_res[l*DATA_W +: DATA_W];
            assign v_iout  = iout_res[l*DATA_W +: DATA_W];
            assign rail_on = RAIL_W'(l) < rails_eff;
        end else begin : g_spare
            assign v_vout  = '0;
            assign v_iout  = '0;
            assign rail_on = 1'b0;
        end

        always_comb begin
            val      = '0;
            lim      = '0;
            en       = 1'b0;
            under_en = 1'b1;
            if (arb_grant[CLS_VOUT]) begin
                val = v_vout;
                lim = lim_vo;
                en  = rail_on;
            end else if (arb_grant[CLS_IOUT]) begin
                val = v_iout;
                lim = lim_io;
                en  = rail_on;
            end else if (arb_grant[CLS_INPUT]) begin
                if (l == 0) begin
                    val = vin_res;
                    lim = lim_vi;
                    en  = 1'b1;
                end else if (l == 1) begin
                    val = iin_res;
                    lim = lim_ii;
                    en  = 1'b1;
                end
            end else if (arb_grant[CLS_TEMP]) begin
                if (l == 0) begin
                    val      = temp_res;
                    lim.of   = temp_lim[DATA_W-1:0];
                    lim.ow   = temp_lim[2*DATA_W-1:DATA_W];
                    en       = 1'b1;
                    under_en = 1'b0;
                end
            end
        end

        tlm_check_lane #(.W(DATA_W)) u_lane (
            .en        (en),
            .under_en  (under_en),
            .value     (val),
            .over_flt  (lim.of),
            .over_wrn  (lim.ow),
            .under_wrn (lim.uw),
            .under_flt (lim.uf),
            .verdict   (lane_vd[l])
        );
    end

    // ---------------- verdict to status index ----------------
    logic [NQ-1:0] warn_det, fault_det;

    always_comb begin
        warn_det  = '0;
        fault_det = '0;
        for (int r = 0; r < N_RAILS; r++) begin
            if (arb_grant[CLS_VOUT]) begin
                warn_det[qi_vout(r)]  = lane_vd[r].warn;
                fault_det[qi_vout(r)] = lane_vd[r].fault;
            end
            if (arb_grant[CLS_IOUT]) begin
                warn_det[qi_iout(r, N_RAILS)]  = lane_vd[r].warn;
                fault_det[qi_iout(r, N_RAILS)] = lane_vd[r].fault;
            end
        end
        if (arb_grant[CLS_INPUT]) begin
            warn_det[qi_vin(N_RAILS)]  = lane_vd[0].warn;
            fault_det[qi_vin(N_RAILS)] = lane_vd[0].fault;
            warn_det[qi_iin(N_RAILS)]  = lane_vd[1].warn;
            fault_det[qi_iin(N_RAILS)] = lane_vd[1].fault;
        end
        if (arb_grant[CLS_TEMP]) begin
            warn_det[qi_temp(N_RAILS)]  = lane_vd[0].warn;
            fault_det[qi_temp(N_RAILS)] = lane_vd[0].fault;
        end
    end

    tlm_status_bank #(.NQ(NQ)) u_status (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_status),
        .warn_det  (warn_det),
        .fault_det (fault_det),
        .warn_q    (warn_status),
        .fault_q   (fault_status),
        .req_q     (fault_req)
    );

    assign alert = |((warn_status & ~warn_mask) | (fault_status & ~fault_mask));

endmodule

module tlm_limit_monitor_chk #(
    parameter int NQ = 7,
    parameter int NC = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          clr_status,
    input logic [NQ-1:0] warn_status,
    input logic [NQ-1:0] fault_status,
    input logic [NQ-1:0] fault_req,
    input logic          bal_strobe,
    input logic          alert,
    input logic [NC-1:0] grant
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (warn_status == '0 && fault_status == '0 && fault_req == '0 && !bal_strobe));

    a_r7_warn_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_status |=> ((warn_status & $past(warn_status)) == $past(warn_status)));

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_status |=> ((fault_status & $past(fault_status)) == $past(fault_status)));

    a_r8_req_marks_set_bit: assert property (@(posedge clk) disable iff (rst)
        (fault_req != '0) |-> ((fault_req & ~fault_status) == '0));

    a_r8_req_only_new: assert property (@(posedge clk) disable iff (rst)
        (fault_req != '0) |-> ((fault_req & $past(fault_status)) == '0));

    a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (fault_req != '0) |=> ((fault_req & $past(fault_req)) == '0));

    a_r10_one_class: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r2_change_needs_service: assert property (@(posedge clk) disable iff (rst)
        (fault_status != $past(fault_status)) |-> ($past(grant != '0) || $past(clr_status)));

    a_r9_alert_has_source: assert property (@(posedge clk) disable iff (rst)
        alert |-> ((warn_status | fault_status) != '0));

    a_r5_bal_single: assert property (@(posedge clk) disable iff (rst)
        bal_strobe |=> !bal_strobe);
endmodule

bind tlm_limit_monitor tlm_limit_monitor_chk #(
    .NQ(2 * N_RAILS + 3),
    .NC(4)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr_status   (clr_status),
    .warn_status  (warn_status),
    .fault_status (fault_status),
    .fault_req    (fault_req),
    .bal_strobe   (bal_strobe),
    .alert        (alert),
    .grant        (arb_grant)
);

// File: tb/tb_tlm_limit_monitor.sv
`timescale 1ns/1ps
module tb_tlm_limit_monitor;
    localparam int W  = 12;
    localparam int NR = 2;
    localparam int NQ = 2 * NR + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b0;
    logic [1:0] cfg_rails = 2'd2;
    logic clr_status = 1'b0;
    logic [NR*W-1:0] vout_res, iout_res;
    logic [W-1:0] vin_res, iin_res, temp_res;
    logic [4*W-1:0] lim4;
    logic [2*W-1:0] temp_lim;
    logic [NQ-1:0] warn_mask = '0, fault_mask = '0;
    logic [NQ-1:0] warn_status, fault_status, fault_req;
    logic bal_strobe, alert;
    logic [NQ-1:0] eq_warn, eq_fault, eq_req;
    logic eq_bal, eq_alert;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // over-fault 3000, over-warn 2500, under-warn 500, under-fault 200
    assign lim4     = {12'd200, 12'd500, 12'd2500, 12'd3000};
    assign temp_lim = {12'd2500, 12'd3000};

    tlm_limit_monitor #(
        .DATA_W(W), .N_RAILS(NR), .VOUT_TICKS(5), .IOUT_BASE_TICKS(7),
        .INPUT_TICKS(22), .BAL_TICKS(22), .TEMP_TICKS(61)
    ) dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .cfg_rails(cfg_rails),
        .clr_status(clr_status), .vout_res(vout_res), .iout_res(iout_res),
        .vin_res(vin_res), .iin_res(iin_res), .temp_res(temp_res),
        .vout_lim(lim4), .iout_lim(lim4), .vin_lim(lim4), .iin_lim(lim4),
        .temp_lim(temp_lim), .warn_mask(warn_mask), .fault_mask(fault_mask),
        .warn_status(warn_status), .fault_status(fault_status),
        .fault_req(fault_req), .bal_strobe(bal_strobe), .alert(alert)
    );

    tlm_limit_monitor #(
        .DATA_W(W), .N_RAILS(NR), .VOUT_TICKS(8), .IOUT_BASE_TICKS(8),
        .INPUT_TICKS(8), .BAL_TICKS(8), .TEMP_TICKS(8)
    ) dut_eq (
        .clk(clk), .rst(rst), .tick_us(tick_us), .cfg_rails(cfg_rails),
        .clr_status(clr_status), .vout_res(vout_res), .iout_res(iout_res),
        .vin_res(vin_res), .iin_res(iin_res), .temp_res(temp_res),
        .vout_lim(lim4), .iout_lim(lim4), .vin_lim(lim4), .iin_lim(lim4),
        .temp_lim(temp_lim), .warn_mask(warn_mask), .fault_mask(fault_mask),
        .warn_status(eq_warn), .fault_status(eq_fault),
        .fault_req(eq_req), .bal_strobe(eq_bal), .alert(eq_alert)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nominal();
        vout_res   = {12'd1000, 12'd1000};
        iout_res   = {12'd1000, 12'd1000};
        vin_res    = 12'd1000;
        iin_res    = 12'd1000;
        temp_res   = 12'd1000;
        warn_mask  = '0;
        fault_mask = '0;
        clr_status = 1'b0;
        tick_us    = 1'b0;
        cfg_rails  = 2'd2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_us = 1'b1;
        repeat (n) @(negedge clk);
        tick_us = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_status = 1'b1;
        idle(1);
        clr_status = 1'b0;
    endtask

    task automatic t_reset();
        nominal();
        vout_res = {12'd3001, 12'd3001};
        rst = 1'b1;
        run_ticks(6);
        chk("R1 warn in reset", warn_status, '0);
        chk("R1 fault in reset", fault_status, '0);
        rst = 1'b0;
        idle(1);
        chk("R1 req after reset", fault_req, '0);
        chk("R1 alert after reset", alert, 1'b0);
        chk("R1 bal after reset", bal_strobe, 1'b0);
        chk("R1 fault after reset", fault_status, '0);
    endtask

    task automatic t_vout_interval();
        nominal();
        do_reset();
        vout_res[11:0] = 12'd2600;
        run_ticks(2);
        idle(10);
        run_ticks(2);
        chk("R11 no check without ticks", warn_status, '0);
        run_ticks(1);
        chk("R2 not before service edge", warn_status, '0);
        idle(1);
        chk("R2 vout warn rail0", warn_status, 7'b0000001);
        vout_res[23:12] = 12'd2600;
        idle(3);
        chk("R11 value change between checks ignored", warn_status, 7'b0000001);
        run_ticks(5);
        idle(1);
        chk("R2 second vout check", warn_status, 7'b0000011);
    endtask

    task automatic t_compare();
        nominal();
        do_reset();
        vout_res = {12'd2500, 12'd3001};
        run_ticks(5);
        idle(1);
        chk("R6 above over-fault warn", warn_status, 7'b0000001);
        chk("R6 above over-fault fault", fault_status, 7'b0000001);
        pulse_clear();
        chk("R7 clear warn", warn_status, '0);
        chk("R7 clear fault", fault_status, '0);
        vout_res = {12'd499, 12'd199};
        run_ticks(5);
        idle(1);
        chk("R6 below under limits warn", warn_status, 7'b0000011);
        chk("R6 below under limits fault", fault_status, 7'b0000001);
        pulse_clear();
        vout_res = {12'd500, 12'd200};
        run_ticks(5);
        idle(1);
        chk("R6 equal limits warn", warn_status, 7'b0000001);
        chk("R6 equal limits fault", fault_status, '0);
    endtask

    task automatic t_iout();
        nominal();
        do_reset();
        iout_res[23:12] = 12'd3001;
        run_ticks(13);
        idle(1);
        chk("R3 iout early", fault_status, '0);
        run_ticks(1);
        chk("R3 iout before service", fault_status, '0);
        chk("R8 no req yet", fault_req, '0);
        idle(1);
        chk("R3 iout rail1 fault", fault_status, 7'b0001000);
        chk("R8 req pulse", fault_req, 7'b0001000);
        idle(1);
        chk("R8 req one cycle", fault_req, '0);
        nominal();
        cfg_rails = 2'd1;
        iout_res = {12'd3001, 12'd3001};
        do_reset();
        run_ticks(7);
        idle(1);
        chk("R3 one rail period and rail1 ignored", fault_status, 7'b0000100);
        nominal();
        cfg_rails = 2'd0;
        iout_res = {12'd3001, 12'd3001};
        do_reset();
        run_ticks(6);
        idle(1);
        chk("R3 zero rails early", fault_status, '0);
        run_ticks(1);
        idle(1);
        chk("R3 zero rails clamps to one", fault_status, 7'b0000100);
        nominal();
        cfg_rails = 2'd3;
        iout_res = {12'd3001, 12'd3001};
        do_reset();
        run_ticks(13);
        idle(1);
        chk("R3 three rails early", fault_status, '0);
        run_ticks(1);
        idle(1);
        chk("R3 three rails clamps to two", fault_status, 7'b0001100);
    endtask

    task automatic t_input_temp();
        nominal();
        do_reset();
        vin_res  = 12'd3001;
        iin_res  = 12'd499;
        temp_res = 12'd2600;
        run_ticks(21);
        idle(1);
        chk("R4 input early warn", warn_status, '0);
        chk("R4 input early fault", fault_status, '0);
        run_ticks(1);
        idle(1);
        chk("R4 input warn", warn_status, 7'b0110000);
        chk("R4 input fault", fault_status, 7'b0010000);
        run_ticks(38);
        idle(1);
        chk("R4 temp early", warn_status[6], 1'b0);
        run_ticks(1);
        idle(1);
        chk("R4 temp warn", warn_status[6], 1'b1);
        pulse_clear();
        temp_res = 12'd0;
        run_ticks(61);
        idle(1);
        chk("R6 temp no under warn", warn_status[6], 1'b0);
        chk("R6 temp no under fault", fault_status[6], 1'b0);
    endtask

    task automatic t_balance();
        nominal();
        do_reset();
        run_ticks(21);
        chk("R5 bal early", bal_strobe, 1'b0);
        run_ticks(1);
        chk("R5 bal pulse", bal_strobe, 1'b1);
        idle(1);
        chk("R5 bal one cycle", bal_strobe, 1'b0);
        run_ticks(21);
        chk("R5 bal second early", bal_strobe, 1'b0);
        run_ticks(1);
        chk("R5 bal second pulse", bal_strobe, 1'b1);
    endtask

    task automatic t_sticky_alert();
        nominal();
        do_reset();
        vout_res[11:0] = 12'd2600;
        run_ticks(5);
        idle(1);
        chk("R9 alert on warn", alert, 1'b1);
        vout_res[11:0] = 12'd1000;
        run_ticks(5);
        idle(1);
        chk("R7 warn sticky", warn_status, 7'b0000001);
        warn_mask = 7'b0000001;
        idle(1);
        chk("R9 masked warn", alert, 1'b0);
        vout_res[23:12] = 12'd3001;
        run_ticks(5);
        idle(1);
        chk("R9 fault sets", fault_status, 7'b0000010);
        warn_mask = '1;
        idle(1);
        chk("R9 unmasked fault alerts", alert, 1'b1);
        fault_mask = 7'b0000010;
        idle(1);
        chk("R9 all masked", alert, 1'b0);
        warn_mask = '0;
        fault_mask = '0;
        vout_res = {12'd1000, 12'd2600};
        run_ticks(4);
        tick_us = 1'b1;
        idle(1);
        tick_us = 1'b0;
        clr_status = 1'b1;
        idle(1);
        clr_status = 1'b0;
        chk("R7 set beats clear warn", warn_status, 7'b0000001);
        chk("R7 clear on service edge fault", fault_status, '0);
    endtask

    task automatic t_priority();
        nominal();
        cfg_rails = 2'd1;
        vout_res = {12'd1000, 12'd2600};
        iout_res = {12'd1000, 12'd2600};
        vin_res  = 12'd2600;
        iin_res  = 12'd2600;
        temp_res = 12'd2600;
        do_reset();
        run_ticks(8);
        chk("R10 none before service", eq_warn, '0);
        idle(1);
        chk("R10 voltage first", eq_warn, 7'b0000001);
        idle(1);
        chk("R10 current second", eq_warn, 7'b0000101);
        idle(1);
        chk("R10 input third", eq_warn, 7'b0110101);
        idle(1);
        chk("R10 temperature last", eq_warn, 7'b1110101);
    endtask

    initial begin
        nominal();
        idle(1);
        t_reset();
        t_vout_interval();
        t_compare();
        t_iout();
        t_input_temp();
        t_balance();
        t_sticky_alert();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule